// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the request path of a host-to-local-bus bridge. Each incoming request carries a 40-bit address and a direction (sized read or sized write). The block decides whether the bridge claims the request. When the bridge claims it, the block also produces the downstream bus command, the downstream address and a flag that asks for a dual-address cycle. Requests arrive on a valid/ready stream, and one result beat leaves on a second valid/ready stream for every request taken in. Rejected requests also yield a beat, so that upstream logic can forward them elsewhere.

The decoder compares the address against two regions of the flat 40-bit space: the memory-mapped region and the I/O region.
- **Memory region.** A claim here can come from the non-prefetchable memory window or from the prefetchable window, and both are gated by a memory enable. The legacy display memory hole is claimed as well while the display-legacy enable is set.
- **I/O region.** The top 15 address bits are removed from any address in this region. The remaining value is checked against the I/O window, which an I/O enable gates. While the ISA-alias enable is set, holes are cut in the low 64 KB of that window. The display-legacy I/O ranges are added back in.

The configuration fields are plain inputs. They are sampled in the cycle in which a request is taken.

On the output stream, a result stays unchanged for as long as `rsp_valid` is high and `rsp_ready` is low. The input may take a new request in any cycle in which the output register is empty or is being drained in that same cycle (`req_ready = !rsp_valid || rsp_ready`). A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Its result appears on `rsp_*` right after that edge.

Top module: `xbr_window_decoder`

## Requirements
- R1: With `cfg_mem_en` set, an address below 4 GB whose bits 31:20 lie inclusively between `cfg_mem_base` and `cfg_mem_limit` is claimed.
- R2: With `cfg_mem_en` set, an address no higher than FC_FFFF_FFFFh whose bits 39:20 lie inclusively between {`cfg_pf_base_hi`,`cfg_pf_base`} and {`cfg_pf_limit_hi`,`cfg_pf_limit`} is claimed.
- R3: With `cfg_mem_en` clear, neither memory window claims anything. A window whose base is greater than its limit claims nothing.
- R4: With `cfg_vga_en` set, addresses 0A_0000h to 0B_FFFFh are claimed as memory. This holds whatever the state of `cfg_mem_en`.
- R5: For a claimed memory request, the command is a read (code 0) or a write (code 1), following `req_wr`. The address is passed through unchanged. `rsp_dac` is 1 exactly when the address is 4 GB or above.
- R6: The I/O region is FD_FC00_0000h to FD_FDFF_FFFFh. For a claimed I/O request, the address is the low 25 bits with zeros above them, the command is a read (code 2) or a write (code 3), and `rsp_dac` is 0.
- R7: With `cfg_io_en` set, an I/O address (after bit removal) whose bits 31:12 lie inclusively between {`cfg_io_base_hi`,`cfg_io_base`} and {`cfg_io_limit_hi`,`cfg_io_limit`} is claimed. With `cfg_io_en` clear, the window claims nothing.
- R8: With `cfg_isa_en` set, the window does not claim an I/O address below 10000h whose bits 9:8 are nonzero. Addresses at 10000h and above are unaffected.
- R9: With `cfg_vga_en` set, an I/O address below 10000h is claimed if its bits 9:0 lie in 3B0h–3BBh or 3C0h–3DFh. This holds regardless of `cfg_io_en`, `cfg_isa_en` and the window.
- R10: Addresses outside both regions are never claimed. A rejected beat carries `rsp_accept`=0, `rsp_cmd`=0, `rsp_addr`=0 and `rsp_dac`=0.
- R11: Each request taken gives exactly one beat, in order, visible right after the edge that takes it. While the beat is stalled, it is held stable. `req_ready` equals `!rsp_valid || rsp_ready`.
- R12: During reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 40 | Request address |
| req_wr | input | 1 | 1 = sized write, 0 = sized read |
| cfg_mem_en | input | 1 | Memory space enable |
| cfg_io_en | input | 1 | I/O space enable |
| cfg_isa_en | input | 1 | ISA alias hole enable |
| cfg_vga_en | input | 1 | Display-legacy window enable |
| cfg_mem_base | input | 12 | Memory window base, address bits 31:20 |
| cfg_mem_limit | input | 12 | Memory window limit, address bits 31:20 |
| cfg_pf_base | input | 12 | Prefetchable base, address bits 31:20 |
| cfg_pf_limit | input | 12 | Prefetchable limit, address bits 31:20 |
| cfg_pf_base_hi | input | 32 | Prefetchable base, address bits 63:32 |
| cfg_pf_limit_hi | input | 32 | Prefetchable limit, address bits 63:32 |
| cfg_io_base | input | 4 | I/O base, address bits 15:12 |
| cfg_io_limit | input | 4 | I/O limit, address bits 15:12 |
| cfg_io_base_hi | input | 16 | I/O base, address bits 31:16 |
| cfg_io_limit_hi | input | 16 | I/O limit, address bits 31:16 |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result can be taken |
| rsp_accept | output | 1 | Request claimed by the bridge |
| rsp_cmd | output | 2 | 0 mem read, 1 mem write, 2 I/O read, 3 I/O write |
| rsp_addr | output | 40 | Downstream address |
| rsp_dac | output | 1 | Dual-address cycle needed |

## Verification
Some properties are checked by the assertions on every cycle. A stalled result must not change. A taken request must fill the output register. An I/O result must never carry the dual-address flag or address bits above bit 24. The dual-address flag of a memory result must match its upper address bits. A rejected beat must be all zeros. The memory and I/O decodes must never both fire. Other behaviour is shown only by the bench scenarios, through its reference model: the exact window edges, the effect of each enable, the ISA alias holes and their end at 64 KB, the display-legacy aliases, and the empty window when base is greater than limit.

// File: rtl/xbr_dec_pkg.sv
package xbr_dec_pkg;
  localparam int ADDR_W    = 40;
  localparam int IO_STRIP  = 15;
  localparam int IO_ADDR_W = ADDR_W - IO_STRIP;
  localparam int LEGACY_W  = 16;  // low 64 KB of I/O space
  localparam int ALIAS_W   = 10;  // 1 KB alias block
  localparam int ISA_LOW_W = ALIAS_W - 2;  // first quarter of the block is kept
  localparam int NVGA_IO   = 2;

  localparam logic [ADDR_W-1:0] MEM_SPACE_TOP = 40'hFC_FFFF_FFFF;
  localparam logic [ADDR_W-1:0] IO_SPACE_LO   = 40'hFD_FC00_0000;
  localparam logic [ADDR_W-1:0] IO_SPACE_HI   = 40'hFD_FDFF_FFFF;
  localparam logic [ADDR_W-1:0] VGA_MEM_LO    = 40'h00_000A_0000;
  localparam logic [ADDR_W-1:0] VGA_MEM_HI    = 40'h00_000B_FFFF;

  localparam logic [NVGA_IO-1:0][ALIAS_W-1:0] VGA_IO_LO = {10'h3C0, 10'h3B0};
  localparam logic [NVGA_IO-1:0][ALIAS_W-1:0] VGA_IO_HI = {10'h3DF, 10'h3BB};

  typedef enum logic [1:0] {
    DN_MEM_RD = 2'd0,
    DN_MEM_WR = 2'd1,
    DN_IO_RD  = 2'd2,
    DN_IO_WR  = 2'd3
  } dn_cmd_e;

  typedef struct packed {
    logic              accept;
    dn_cmd_e           cmd;
    logic [ADDR_W-1:0] addr;
    logic              dac;
  } dec_res_t;
endpackage

// File: rtl/xbr_range_cmp.sv
module xbr_range_cmp #(
  parameter int W = 12
) (
  input  logic [W-1:0] key,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);
  // inclusive at both ends; an inverted window is empty
  assign hit = (lo <= hi) && (key >= lo) && (key <= hi);
endmodule

// File: rtl/xbr_mem_decode.sv
module xbr_mem_decode
  import xbr_dec_pkg::*;
#(
  parameter int MEM_SHIFT   = 20,
  parameter int PF_HI_W     = 32,
  parameter bit VGA_SUPPORT = 1'b1
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      mem_en,
  input  logic                      vga_en,
  input  logic [32-MEM_SHIFT-1:0]   mem_base,
  input  logic [32-MEM_SHIFT-1:0]   mem_limit,
  input  logic [32-MEM_SHIFT-1:0]   pf_base,
  input  logic [32-MEM_SHIFT-1:0]   pf_limit,
  input  logic [PF_HI_W-1:0]        pf_base_hi,
  input  logic [PF_HI_W-1:0]        pf_limit_hi,
  output logic                      hit,
  output logic                      dac
);
  localparam int LO_W  = 32 - MEM_SHIFT;
  localparam int PF_W  = PF_HI_W + LO_W;
  localparam int KEY_W = ADDR_W - MEM_SHIFT;

  logic in_space, below_4g, win_hit, pf_hit, vga_hit;
  logic [PF_W-1:0] pf_key;

  assign in_space = (addr <= MEM_SPACE_TOP);
  assign below_4g = (addr[ADDR_W-1:32] == '0);
  assign pf_key   = {{(PF_W-KEY_W){1'b0}}, addr[ADDR_W-1:MEM_SHIFT]};

  xbr_range_cmp #(.W(LO_W)) u_win (
    .key(addr[31:MEM_SHIFT]), .lo(mem_base), .hi(mem_limit), .hit(win_hit)
  );

  xbr_range_cmp #(.W(PF_W)) u_pf (
    .key(pf_key), .lo({pf_base_hi, pf_base}), .hi({pf_limit_hi, pf_limit}), .hit(pf_hit)
  );

  generate
    if (VGA_SUPPORT) begin : g_vga
      assign vga_hit = vga_en && (addr >= VGA_MEM_LO) && (addr <= VGA_MEM_HI);
    end else begin : g_no_vga
      assign vga_hit = 1'b0;
    end
  endgenerate

  assign hit = vga_hit || (in_space && mem_en && ((win_hit && below_4g) || pf_hit));
  assign dac = !below_4g;
endmodule

// File: rtl/xbr_io_decode.sv
module xbr_io_decode
  import xbr_dec_pkg::*;
#(
  parameter int IO_SHIFT    = 12,
  parameter int IO_HI_W     = 16,
  parameter bit VGA_SUPPORT = 1'b1
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     io_en,
  input  logic                     isa_en,
  input  logic                     vga_en,
  input  logic [16-IO_SHIFT-1:0]   io_base,
  input  logic [16-IO_SHIFT-1:0]   io_limit,
  input  logic [IO_HI_W-1:0]       io_base_hi,
  input  logic [IO_HI_W-1:0]       io_limit_hi,
  output logic                     hit,
  output logic [IO_ADDR_W-1:0]     io_addr
);
  localparam int LO_W  = 16 - IO_SHIFT;
  localparam int WIN_W = IO_HI_W + LO_W;
  localparam int KEY_W = IO_ADDR_W - IO_SHIFT;

  logic in_space, legacy, win_hit, isa_hole, vga_hit;
  logic [WIN_W-1:0]   win_key;
  logic [ALIAS_W-1:0] low_bits;

  assign in_space = (addr >= IO_SPACE_LO) && (addr <= IO_SPACE_HI);
  assign io_addr  = addr[IO_ADDR_W-1:0];
  assign low_bits = io_addr[ALIAS_W-1:0];
  assign legacy   = (io_addr[IO_ADDR_W-1:LEGACY_W] == '0);
  assign win_key  = {{(WIN_W-KEY_W){1'b0}}, io_addr[IO_ADDR_W-1:IO_SHIFT]};

  xbr_range_cmp #(.W(WIN_W)) u_win (
    .key(win_key), .lo({io_base_hi, io_base}), .hi({io_limit_hi, io_limit}), .hit(win_hit)
  );

  // alias holes: upper three quarters of each 1 KB block below 64 KB
  assign isa_hole = isa_en && legacy && (io_addr[ALIAS_W-1:ISA_LOW_W] != '0);

  generate
    if (VGA_SUPPORT) begin : g_vga
      logic [NVGA_IO-1:0] sub_hit;
      for (genvar i = 0; i < NVGA_IO; i++) begin : g_rng
        assign sub_hit[i] = (low_bits >= VGA_IO_LO[i]) && (low_bits <= VGA_IO_HI[i]);
      end
      assign vga_hit = vga_en && legacy && (|sub_hit);
    end else begin : g_no_vga
      assign vga_hit = 1'b0;
    end
  endgenerate

  assign hit = in_space && ((io_en && win_hit && !isa_hole) || vga_hit);
endmodule

// File: rtl/xbr_rsp_reg.sv
module xbr_rsp_reg
  import xbr_dec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  dec_res_t in_data,
  output logic     out_valid,
  input  logic     out_ready,
  output dec_res_t out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: rtl/xbr_window_decoder.sv
module xbr_window_decoder
  import xbr_dec_pkg::*;
#(
  parameter int MEM_SHIFT   = 20,
  parameter int PF_HI_W     = 32,
  parameter int IO_SHIFT    = 12,
  parameter int IO_HI_W     = 16,
  parameter bit VGA_SUPPORT = 1'b1,
  localparam int MEM_LO_W   = 32 - MEM_SHIFT,
  localparam int IO_LO_W    = 16 - IO_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_wr,
  input  logic                 cfg_mem_en,
  input  logic                 cfg_io_en,
  input  logic                 cfg_isa_en,
  input  logic                 cfg_vga_en,
  input  logic [MEM_LO_W-1:0]  cfg_mem_base,
  input  logic [MEM_LO_W-1:0]  cfg_mem_limit,
  input  logic [MEM_LO_W-1:0]  cfg_pf_base,
  input  logic [MEM_LO_W-1:0]  cfg_pf_limit,
  input  logic [PF_HI_W-1:0]   cfg_pf_base_hi,
  input  logic [PF_HI_W-1:0]   cfg_pf_limit_hi,
  input  logic [IO_LO_W-1:0]   cfg_io_base,
  input  logic [IO_LO_W-1:0]   cfg_io_limit,
  input  logic [IO_HI_W-1:0]   cfg_io_base_hi,
  input  logic [IO_HI_W-1:0]   cfg_io_limit_hi,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_accept,
  output logic [1:0]           rsp_cmd,
  output logic [ADDR_W-1:0]    rsp_addr,
  output logic                 rsp_dac
);
  logic                 mem_hit, mem_dac, io_hit;
  logic [IO_ADDR_W-1:0] io_addr;
  dec_res_t             res, held;

  xbr_mem_decode #(.MEM_SHIFT(MEM_SHIFT), .PF_HI_W(PF_HI_W), .VGA_SUPPORT(VGA_SUPPORT)) u_mem (
    .addr(req_addr), .mem_en(cfg_mem_en), .vga_en(cfg_vga_en),
    .mem_base(cfg_mem_base), .mem_limit(cfg_mem_limit),
    .pf_base(cfg_pf_base), .pf_limit(cfg_pf_limit),
    .pf_base_hi(cfg_pf_base_hi), .pf_limit_hi(cfg_pf_limit_hi),
    .hit(mem_hit), .dac(mem_dac)
  );

  xbr_io_decode #(.IO_SHIFT(IO_SHIFT), .IO_HI_W(IO_HI_W), .VGA_SUPPORT(VGA_SUPPORT)) u_io (
    .addr(req_addr), .io_en(cfg_io_en), .isa_en(cfg_isa_en), .vga_en(cfg_vga_en),
    .io_base(cfg_io_base), .io_limit(cfg_io_limit),
    .io_base_hi(cfg_io_base_hi), .io_limit_hi(cfg_io_limit_hi),
    .hit(io_hit), .io_addr(io_addr)
  );

  always_comb begin
    res = '0;
    if (io_hit) begin
      res.accept = 1'b1;
      res.cmd    = req_wr ? DN_IO_WR : DN_IO_RD;
      res.addr   = {{IO_STRIP{1'b0}}, io_addr};
    end else if (mem_hit) begin
      res.accept = 1'b1;
      res.cmd    = req_wr ? DN_MEM_WR : DN_MEM_RD;
      res.addr   = req_addr;
      res.dac    = mem_dac;
    end
  end

  xbr_rsp_reg u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(res),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(held)
  );

  assign rsp_accept = held.accept;
  assign rsp_cmd    = held.cmd;
  assign rsp_addr   = held.addr;
  assign rsp_dac    = held.dac;

  assert_space_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(mem_hit && io_hit));

  assert_reject_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_accept |-> rsp_cmd == 2'd0 && rsp_addr == '0 && !rsp_dac);

  assert_io_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_accept && rsp_cmd[1] |-> !rsp_dac && rsp_addr[ADDR_W-1:IO_ADDR_W] == '0);

  assert_mem_dac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_accept && !rsp_cmd[1] |-> rsp_dac == (rsp_addr[ADDR_W-1:32] != '0));
endmodule

// File: tb/sim_xbr_window_decoder.sv
module sim_xbr_window_decoder;
  import xbr_dec_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        req_valid = 1'b0, req_ready, req_wr = 1'b0;
  logic [39:0] req_addr = '0;
  logic        mem_en, io_en, isa_en, vga_en;
  logic [11:0] mem_base, mem_limit, pf_base, pf_limit;
  logic [31:0] pf_base_hi, pf_limit_hi;
  logic [3:0]  io_base, io_limit;
  logic [15:0] io_base_hi, io_limit_hi;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_accept, rsp_dac;
  logic [1:0]  rsp_cmd;
  logic [39:0] rsp_addr;

  int n_chk = 0, n_err = 0;
  dec_res_t exp_q[$];
  string    tag_q[$];
  logic     bp_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  xbr_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wr(req_wr),
    .cfg_mem_en(mem_en), .cfg_io_en(io_en), .cfg_isa_en(isa_en), .cfg_vga_en(vga_en),
    .cfg_mem_base(mem_base), .cfg_mem_limit(mem_limit),
    .cfg_pf_base(pf_base), .cfg_pf_limit(pf_limit),
    .cfg_pf_base_hi(pf_base_hi), .cfg_pf_limit_hi(pf_limit_hi),
    .cfg_io_base(io_base), .cfg_io_limit(io_limit),
    .cfg_io_base_hi(io_base_hi), .cfg_io_limit_hi(io_limit_hi),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_accept(rsp_accept),
    .rsp_cmd(rsp_cmd), .rsp_addr(rsp_addr), .rsp_dac(rsp_dac)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model built from the address map rules
  function automatic dec_res_t model(input logic [39:0] a, input logic wr);
    dec_res_t r;
    logic [63:0] lo, hi, ioa, l10;
    bit mh, ih;
    r = '0; mh = 0; ih = 0;
    if (mem_en && a <= 40'hFC_FFFF_FFFF) begin
      lo = {32'h0, mem_base, 20'h00000};
      hi = {32'h0, mem_limit, 20'hFFFFF};
      if (64'(a) >= lo && 64'(a) <= hi) mh = 1;
      lo = {pf_base_hi, pf_base, 20'h00000};
      hi = {pf_limit_hi, pf_limit, 20'hFFFFF};
      if (64'(a) >= lo && 64'(a) <= hi) mh = 1;
    end
    if (vga_en && a >= 40'hA_0000 && a <= 40'hB_FFFF) mh = 1;
    if (a >= 40'hFD_FC00_0000 && a <= 40'hFD_FDFF_FFFF) begin
      ioa = 64'(a - 40'hFD_FC00_0000);
      l10 = ioa % 1024;
      lo = {32'h0, io_base_hi, io_base, 12'h000};
      hi = {32'h0, io_limit_hi, io_limit, 12'hFFF};
      if (io_en && ioa >= lo && ioa <= hi &&
          !(isa_en && ioa < 64'h10000 && l10 >= 256)) ih = 1;
      if (vga_en && ioa < 64'h10000 &&
          ((l10 >= 64'h3B0 && l10 <= 64'h3BB) || (l10 >= 64'h3C0 && l10 <= 64'h3DF))) ih = 1;
      if (ih) begin
        r.accept = 1; r.cmd = wr ? DN_IO_WR : DN_IO_RD; r.addr = ioa[39:0]; r.dac = 0;
      end
    end
    if (!ih && mh) begin
      r.accept = 1; r.cmd = wr ? DN_MEM_WR : DN_MEM_RD; r.addr = a;
      r.dac = (a >= 40'h1_0000_0000);
    end
    return r;
  endfunction

  task automatic send(input logic [39:0] a, input logic wr, input string tag);
    bit got;
    got = 0;
    req_addr = a; req_wr = wr; req_valid = 1'b1;
    while (!got) begin
      @(negedge clk);
      if (req_ready) begin
        exp_q.push_back(model(a, wr));
        tag_q.push_back(tag);
        got = 1;
      end
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R11", "beat after take", 64'(rsp_valid), 64'd1);
  endtask

  task automatic cfg_base();
    mem_en = 1; io_en = 1; isa_en = 0; vga_en = 0;
    mem_base = 12'h100; mem_limit = 12'h1FF;
    pf_base = 12'h000; pf_base_hi = 32'h2; pf_limit = 12'hFFF; pf_limit_hi = 32'h2;
    io_base = 4'h1; io_base_hi = 16'h0; io_limit = 4'h3; io_limit_hi = 16'h0;
  endtask

  // back-pressure source
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_ready = bp_en ? lfsr[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  logic        hold_pend = 1'b0;
  logic [43:0] hold_val;
  initial begin
    dec_res_t e;
    string    t;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_pend) begin
          chk(rsp_valid === 1'b1 && {rsp_accept, rsp_cmd, rsp_addr, rsp_dac} === hold_val,
              "R11", "stalled beat held",
              64'({rsp_valid, rsp_accept, rsp_cmd, rsp_addr, rsp_dac}), 64'({1'b1, hold_val}));
          hold_pend = 1'b0;
        end
        if (rsp_valid && rsp_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R11", "unexpected beat", 64'(rsp_addr), 64'd0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({rsp_accept, rsp_cmd, rsp_addr, rsp_dac} === {e.accept, e.cmd, e.addr, e.dac},
                t, "acc/cmd/addr/dac",
                64'({rsp_accept, rsp_cmd, rsp_addr, rsp_dac}), 64'({e.accept, e.cmd, e.addr, e.dac}));
          end
        end else if (rsp_valid) begin
          hold_pend = 1'b1;
          hold_val  = {rsp_accept, rsp_cmd, rsp_addr, rsp_dac};
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    cfg_base();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R12", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk(req_ready === 1'b1, "R12", "req_ready in reset", 64'(req_ready), 64'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // memory window edges
    send(40'h00_1000_0000, 0, "R1");
    send(40'h00_1FFF_FFFF, 1, "R1");
    send(40'h00_2000_0000, 0, "R1");
    send(40'h00_0FFF_FFFF, 0, "R1");
    // prefetchable window above 4 GB
    send(40'h02_0000_0000, 0, "R2");
    send(40'h02_FFFF_FFFF, 1, "R5");
    send(40'h03_0000_0000, 0, "R2");
    send(40'h01_FFFF_FFFF, 1, "R2");
    // legacy display memory
    send(40'h00_000A_0000, 0, "R4");
    vga_en = 1;
    send(40'h00_000A_0000, 0, "R4");
    send(40'h00_000B_FFFF, 1, "R4");
    send(40'h00_000C_0000, 0, "R4");
    send(40'h00_0009_FFFF, 0, "R4");
    // memory enable off
    mem_en = 0;
    send(40'h00_1000_0000, 0, "R3");
    send(40'h02_0000_0000, 1, "R3");
    send(40'h00_000A_1234, 1, "R4");
    // inverted windows
    mem_en = 1; vga_en = 0;
    mem_base = 12'h200; mem_limit = 12'h1FF;
    pf_base_hi = 32'h3; pf_limit_hi = 32'h2;
    send(40'h00_1FFF_FFFF, 0, "R3");
    send(40'h00_2000_0000, 0, "R3");
    send(40'h02_8000_0000, 0, "R3");
    cfg_base();
    // I/O window
    send(40'hFD_FC00_1000, 0, "R6");
    send(40'hFD_FC00_3FFF, 1, "R6");
    send(40'hFD_FC00_4000, 0, "R7");
    send(40'hFD_FC00_0FFF, 1, "R7");
    // ISA alias holes
    isa_en = 1;
    send(40'hFD_FC00_1100, 0, "R8");
    send(40'hFD_FC00_10FF, 0, "R8");
    send(40'hFD_FC00_13FF, 1, "R8");
    send(40'hFD_FC00_1400, 1, "R8");
    io_base = 4'h0; io_base_hi = 16'h1; io_limit = 4'hF; io_limit_hi = 16'h1;
    send(40'hFD_FC01_0100, 0, "R8");
    send(40'hFD_FC00_1000, 0, "R7");
    io_en = 0;
    send(40'hFD_FC01_0100, 0, "R7");
    // display-legacy I/O aliases
    vga_en = 1;
    send(40'hFD_FC00_03B0, 0, "R9");
    send(40'hFD_FC00_03BB, 0, "R9");
    send(40'hFD_FC00_03BC, 0, "R9");
    send(40'hFD_FC00_03C0, 0, "R9");
    send(40'hFD_FC00_03DF, 1, "R9");
    send(40'hFD_FC00_03E0, 0, "R9");
    send(40'hFD_FC00_07B0, 1, "R9");
    send(40'hFD_FC01_03B0, 0, "R9");
    // region boundaries
    cfg_base();
    pf_base = 12'h000; pf_base_hi = 32'hFC; pf_limit = 12'hFFF; pf_limit_hi = 32'hFF;
    io_base = 4'h0; io_base_hi = 16'h0; io_limit = 4'hF; io_limit_hi = 16'hFFFF;
    send(40'hFC_FFFF_FFFF, 0, "R2");
    send(40'hFD_0000_0000, 0, "R10");
    send(40'hFD_FBFF_FFFF, 1, "R10");
    send(40'hFD_FDFF_FFFF, 1, "R6");
    send(40'hFD_FE00_0000, 0, "R10");
    send(40'hFF_FFFF_FFFF, 0, "R10");
    // mixed traffic under back-pressure
    cfg_base();
    bp_en = 1;
    for (int i = 0; i < 40; i++) begin
      case (i % 4)
        0: send(40'h00_1000_0000 + 40'(i) * 40'h1000, i[0], "R11");
        1: send(40'hFD_FC00_1000 + 40'(i), i[1], "R11");
        2: send(40'h02_0000_0000 + 40'(i), i[2], "R11");
        default: send(40'hFD_0000_0000 + 40'(i), i[0], "R10");
      endcase
    end
    bp_en = 0;
    repeat (4) @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R11", "no extra beats", 64'(rsp_valid), 64'd0);
    chk(exp_q.size() == 0, "R11", "all beats seen", 64'(exp_q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule